// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read path of a byte-wide nonvolatile memory whose writes run as self-timed cycles. When the host reads, the block puts either the true array byte or a status word on the data pins, so the host can tell whether a write is still in progress without a separate status register. While the write engine reports busy, the top data bit of a read returns the inverse of the top bit of the byte last written, but only when the address matches the last written address. The next bit down flips between successive busy reads. Once busy clears, every read returns true array data.

A read is recognised in any cycle where chip enable and output enable are both low and write enable is high. All control inputs are active-low and arrive already synchronous to `clk`. The result is registered, so the data pins and their driver enable follow the read strobe by one clock. When the driver enable is low, the pad drivers release the bus.

Top module: `ws_status_reporter`

## Requirements
- R1: `dq_oe` is 1 in the cycle after a cycle in which `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 in the cycle after any other input combination.
- R2: Whenever `dq_oe` is 0, `dq_o` is all zeros.
- R3: A read taken while `busy`=0 returns `arr_data` of the read cycle on `dq_o` one clock later.
- R4: A read taken while `busy`=1 at `rd_addr`==`last_addr` returns the complement of `last_data` bit 7 on `dq_o` bit 7.
- R5: A read taken while `busy`=1 at any other address returns 0 on `dq_o` bit 7.
- R6: A read taken while `busy`=1 returns 0 on `dq_o` bits 5 down to 0.
- R7: A read taken while `busy`=1 returns the toggle state on `dq_o` bit 6. The toggle state inverts at the clock edge that ends a read, in the first cycle where the strobe is no longer met, if `busy`=1 in that cycle. Back-to-back busy reads therefore alternate bit 6.
- R8: A read that ends while `busy`=0 leaves the toggle state unchanged. The next busy read shows the value left by the last busy read's end.
- R9: While `rst_n`=0 at a clock edge, `dq_oe`, `dq_o` and the toggle state become 0. The first busy read after reset returns bit 6 = 0.
- R10: With `ce_n`=0 and `oe_n`=0 but `we_n`=0, no read is taken. `dq_oe` stays 0 and the toggle state does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Self-timed write cycle in progress |
| rd_addr | input | ADDR_W (13) | Address of the current read |
| last_addr | input | ADDR_W (13) | Address of the last byte written |
| last_data | input | DATA_W (8) | Last byte written |
| arr_data | input | DATA_W (8) | Array data for `rd_addr` |
| dq_o | output | DATA_W (8) | Registered data toward the pads |
| dq_oe | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
The hardest case to reach is toggle history that crosses a change of `busy`. Examples are a read that starts busy and ends idle, and an idle read placed between two busy reads. In both, bit 6 depends on how many busy read endings came before. The bench keeps a cycle-level model of the toggle state, updated only when a strobe ends while busy. It runs long chains of back-to-back and interrupted reads, then a dedicated busy/idle/busy sequence, and checks bit 6 against that model on every read.

// File: rtl/ws_pkg.sv
// Package: shared types and helpers for the write completion status reporter.
// Assumes the data word is at least three bits wide (poll bit, toggle bit, filler).
package ws_pkg;

    // Source of the next word driven toward the pads
    typedef enum logic [1:0] {
        WS_SRC_RELEASE = 2'd0,
        WS_SRC_ARRAY   = 2'd1,
        WS_SRC_STATUS  = 2'd2
    } ws_src_e;

    // Choose the output source from the read strobe and the busy flag
    function automatic ws_src_e ws_pick_source(input logic rd, input logic busy);
        if (!rd) begin
            return WS_SRC_RELEASE;
        end
        if (busy) begin
            return WS_SRC_STATUS;
        end
        return WS_SRC_ARRAY;
    endfunction

endpackage

// File: rtl/ws_strobe_decode.sv
// Module: decodes the active-low controls into a read strobe and flags the
// cycle in which a read strobe ends. Assumes the controls are already
// synchronous to clk.
module ws_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_now,
    output logic rd_end
);

    logic rd_q;

    // Read strobe: chip and output enabled while write enable is inactive
    always_comb begin
        rd_now = !ce_n && !oe_n && we_n;
    end

    // Remember whether the previous cycle was a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_now;
        end
    end

    // End of read: previous cycle read, this cycle does not
    always_comb begin
        rd_end = rd_q && !rd_now;
    end

endmodule

// File: rtl/ws_toggle_gen.sv
// Module: holds the toggle state reported during busy reads. It inverts on
// every advance request and clears on reset. Assumes the caller already
// qualifies advance with busy.
module ws_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tgl_q
);

    // Invert on each qualified read end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (adv) begin
            tgl_q <= !tgl_q;
        end
    end

endmodule

// File: rtl/ws_word_mux.sv
// Module: builds the next output word. It picks released zeros, true array
// data, or the status word. The status word puts the inverted poll bit in
// the top position, the toggle bit just below it, and zeros elsewhere.
// Assumes DATA_W >= 3.
module ws_word_mux
    import ws_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  ws_src_e           src,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              tgl,
    output logic [DATA_W-1:0] word_nxt
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TGL_BIT  = DATA_W - 2;

    logic              addr_hit;
    logic [DATA_W-1:0] status_word;

    // Address comparison against the last written location
    always_comb begin
        addr_hit = (rd_addr == last_addr);
    end

    // Per-bit construction of the status word
    for (genvar b = 0; b < DATA_W; b++) begin : g_status
        if (b == POLL_BIT) begin : g_poll
            assign status_word[b] = addr_hit && !last_data[POLL_BIT];
        end else if (b == TGL_BIT) begin : g_tgl
            assign status_word[b] = tgl;
        end else begin : g_zero
            assign status_word[b] = 1'b0;
        end
    end

    // Source selection
    always_comb begin
        unique case (src)
            WS_SRC_ARRAY:  word_nxt = arr_data;
            WS_SRC_STATUS: word_nxt = status_word;
            default:       word_nxt = '0;
        endcase
    end

endmodule

// File: rtl/ws_status_reporter.sv
// Module: top of the write completion status reporter. It registers the
// selected word and the pad driver enable one clock after the read strobe.
// Assumes all inputs are synchronous to clk and that busy, last_addr and
// last_data come from the write engine.
module ws_status_reporter
    import ws_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    logic              rd_now;
    logic              rd_end;
    logic              tgl_state;
    logic              tgl_adv;
    ws_src_e           src;
    logic [DATA_W-1:0] word_nxt;

    ws_strobe_decode u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .rd_now (rd_now),
        .rd_end (rd_end)
    );

    // Toggle advances only when a read ends during a write cycle
    always_comb begin
        tgl_adv = rd_end && busy;
    end

    ws_toggle_gen u_toggle (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tgl_adv),
        .tgl_q (tgl_state)
    );

    // Output source for this cycle
    always_comb begin
        src = ws_pick_source(rd_now, busy);
    end

    ws_word_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .src       (src),
        .rd_addr   (rd_addr),
        .last_addr (last_addr),
        .last_data (last_data),
        .arr_data  (arr_data),
        .tgl       (tgl_state),
        .word_nxt  (word_nxt)
    );

    // Output register for pad data and driver enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o  <= '0;
            dq_oe <= 1'b0;
        end else begin
            dq_o  <= word_nxt;
            dq_oe <= rd_now;
        end
    end

endmodule

// File: rtl/ws_checker.sv
// Module: property checker for the status reporter, attached by bind.
module ws_checker #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe,
    input logic              tgl_state,
    input logic              rd_end
);

    localparam int PB = DATA_W - 1;
    localparam int TB = DATA_W - 2;

    logic rd;
    assign rd = !ce_n && !oe_n && we_n;

    assert_read_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> dq_oe);
    assert_read_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !dq_oe);
    assert_bus_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0));
    assert_true_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !busy) |=> (dq_o == $past(arr_data)));
    assert_poll_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy && rd_addr == last_addr) |=> (dq_o[PB] == !$past(last_data[PB])));
    assert_poll_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy && rd_addr != last_addr) |=> !dq_o[PB]);
    assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy) |=> (dq_o[TB-1:0] == '0));
    assert_toggle_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy) |=> (dq_o[TB] == $past(tgl_state)));
    assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && busy) |=> (tgl_state != $past(tgl_state)));
    assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !busy) |=> $stable(tgl_state));
    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (!dq_oe && dq_o == '0 && !tgl_state));
    assert_write_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !we_n) |=> !dq_oe);

endmodule

bind ws_status_reporter ws_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .last_addr (last_addr),
    .last_data (last_data),
    .arr_data  (arr_data),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .tgl_state (tgl_state),
    .rd_end    (rd_end)
);

// File: tb/ws_status_reporter_tb.sv
module ws_status_reporter_tb;

    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic [DW-1:0] arr_data = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;
    logic tgl_m = 1'b0;
    logic prev_rd = 1'b0;

    always #4 clk = !clk;

    ws_status_reporter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .rd_addr(rd_addr), .last_addr(last_addr),
        .last_data(last_data), .arr_data(arr_data), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock with the given inputs; checks outputs at the following negedge
    task automatic cyc(input logic c, input logic o, input logic w, input logic b,
                       input logic [AW-1:0] a, input logic [AW-1:0] la,
                       input logic [DW-1:0] ld, input logic [DW-1:0] ad,
                       input string t6);
        logic          rd;
        logic [DW-1:0] e;
        ce_n = c; oe_n = o; we_n = w; busy = b;
        rd_addr = a; last_addr = la; last_data = ld; arr_data = ad;
        rd = !c && !o && w;
        if (!rd) e = '0;
        else if (!b) e = ad;
        else e = {(a == la) ? !ld[DW-1] : 1'b0, tgl_m, 6'b0};
        if (prev_rd && !rd && b) tgl_m = !tgl_m;
        prev_rd = rd;
        @(posedge clk);
        @(negedge clk);
        if (!rd && !c && !o && !w) chk("R10 oe", {7'b0, dq_oe}, 8'h00);
        else chk("R1 oe", {7'b0, dq_oe}, {7'b0, rd});
        if (!rd) chk("R2 data", dq_o, e);
        else if (!b) chk("R3 data", dq_o, e);
        else begin
            chk((a == la) ? "R4 bit7" : "R5 bit7", {7'b0, dq_o[7]}, {7'b0, e[7]});
            chk(t6, {7'b0, dq_o[6]}, {7'b0, e[6]});
            chk("R6 low", {2'b0, dq_o[5:0]}, 8'h00);
        end
    endtask

    task automatic idle(input logic b);
        cyc(1'b1, 1'b1, 1'b1, b, '0, '0, '0, '0, "R7");
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        @(negedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 oe", {7'b0, dq_oe}, 8'h00);
        chk("R9 data", dq_o, 8'h00);
        rst_n = 1'b1;
        // R9: first busy read after reset shows toggle 0
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 4'd3, 8'h00, 8'h5A, "R9 toggle");
        idle(1'b1);

        // R1, R10: all control combinations, idle and busy
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 8; k++) begin
                cyc(k[2], k[1], k[0], b[0], 4'(k), 4'd2, 8'h3C ^ 8'(k), 8'hA5 ^ 8'(k), "R7");
                idle(b[0]);
            end
        end

        // R3: every array value on an idle read
        for (int d = 0; d < 256; d++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'(d), 4'(d), 8'(~d), 8'(d), "R7");
            idle(1'b0);
        end

        // R4, R5, R6, R7: busy reads across addresses and written values
        for (int la = 0; la < 16; la += 5) begin
            for (int a = 0; a < 16; a++) begin
                for (int d = 0; d < 256; d += 37) begin
                    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'(a), 4'(la), 8'(d), 8'hFF, "R7");
                    idle(1'b1);
                end
            end
        end

        // R7: back-to-back busy reads separated by one released cycle
        for (int n = 0; n < 10; n++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 4'd1, 8'h80, 8'h00, "R7 alt");
            idle(1'b1);
        end

        // R8: busy read, idle read, busy read; idle end must not advance
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 4'd7, 8'h00, 8'h11, "R8");
        idle(1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd7, 4'd7, 8'h00, 8'h22, "R8");
        idle(1'b0);
        idle(1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 4'd7, 8'h00, 8'h33, "R8");
        idle(1'b1);

        // R8: read starting busy and ending idle (busy drops mid-read)
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 4'd9, 8'hFF, 8'h44, "R8");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd9, 4'd9, 8'hFF, 8'h66, "R8");
        idle(1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 4'd9, 8'hFF, 8'h77, "R8");
        idle(1'b1);

        // R10: write-enabled strobe between busy reads must not advance
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 4'd4, 8'h00, 8'h00, "R10");
        idle(1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd4, 4'd4, 8'h00, 8'h00, "R10 toggle");
        idle(1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule